// File: doc/BRIEF.md
# Byte-Parallel Slave Configuration Port

This block is the device side of a byte-wide configuration port. An external controller, such as a processor or a small programmable-logic sequencer, drives an 8-bit data bus, the port clock, an active-high select and an active-high write strobe. When the three mode inputs select parallel loading, each byte written is bit-reversed and placed in a small input FIFO. A drain stage takes at most one byte from the FIFO every other clock, sends it to the configuration sink and stores it.

While the FIFO is full the port raises `busy`. The controller must then hold the same byte on the bus until `busy` falls, and the port takes that byte exactly once. After a parameterized number of bytes has been accepted, `done` rises and stays high. Any further writes are ignored. With select high and write low, the port then drives the stored bytes back in load order, in the bit order they had on the bus. A read address counter steps through them and returns to the first byte whenever select is released.

Top module: `cfg_byte_port`

## Requirements
- R1: Bytes are taken only while `mode_sel` equals 3'b110, where `mode_sel[0]` is the first mode pin and `mode_sel[2]` the third (first pin low, second and third high). Under any other value, writes change nothing.
- R2: A byte on `din` is accepted at a rising clock edge when `cs`, `wr` and the mode match are all true, `busy` is low and `done` is low. At most one byte is accepted per edge.
- R3: `busy` is high exactly while FIFO_DEPTH (default 4) bytes are waiting. A byte presented while `busy` is high is not consumed. The same byte held on the bus is accepted once, at the first edge where `busy` is low.
- R4: The sink emits accepted bytes in arrival order, one per `sink_vld` pulse. `sink_vld` is never high in two consecutive cycles.
- R5: Each sink byte is the bus byte with its bits reversed: `sink_byte[7-i]` equals `din[i]`, so the bit on `din[0]` becomes the most significant bit.
- R6: `done` rises in the cycle after the LOAD_BYTES-th (default 12) accepted byte and stays high until reset. While `done` is high, writes are ignored.
- R7: With `done` high, a mode match, `cs` high and `wr` low, `dout_en` is high and `dout` shows the stored bytes in load order, in the same bit order they had on `din`. Each clock of reading advances by one byte. In every other case `dout_en` and `dout` are zero.
- R8: Deasserting `cs` for at least one clock edge returns the read address to the first loaded byte.
- R9: After the last stored byte, the next read returns the first byte again.
- R10: During reset and after it, `busy`, `done`, `dout_en` and `sink_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock supplied by the controller |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Mode pins; bit 0 is the first pin |
| cs | input | 1 | Select, active high |
| wr | input | 1 | High for write, low for readback |
| din | input | 8 | Write data from the controller |
| dout | output | 8 | Readback data |
| dout_en | output | 1 | High while the port drives readback data |
| busy | output | 1 | Flow-control flag; the controller holds data while it is high |
| done | output | 1 | All expected bytes have been accepted |
| sink_vld | output | 1 | One-cycle pulse marking a byte delivered to the sink |
| sink_byte | output | 8 | Bit-reversed byte delivered to the sink |

## Verification
Acceptance of a new byte and draining of the FIFO head can happen on the same edge, and that edge decides whether the FIFO level holds or rises, and so when `busy` asserts. The bench provokes this with an uninterrupted burst of writes, so pushes overlap the every-other-cycle drain until the FIFO fills and the controller is stalled. It judges the result at the ports: `busy` must assert within a bounded number of cycles, at least one stall must occur, the sink sequence must match the written bytes one for one with none lost or repeated, and `done` must rise exactly after the last accepted byte.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef logic [7:0] byte_t;

    // first pin low, second and third high; mode_sel[0] is the first pin
    localparam logic [2:0] MODE_PARALLEL = 3'b110;

    function automatic byte_t bitrev8(input byte_t b);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[7-i] = b[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgp_fifo.sv
module cfgp_fifo
    import cfgp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  byte_t wdata,
    input  logic  pop,
    output byte_t rdata,
    output logic  full,
    output logic  empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop;

    assign full   = (st_q.cnt == FULLV);
    assign empty  = (st_q.cnt == '0);
    assign rdata  = st_q.mem[st_q.rp];
    assign do_pop = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (push && !full) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({push && !full, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));

endmodule

// File: rtl/cfgp_sink.sv
module cfgp_sink
    import cfgp_pkg::*;
#(
    parameter int LOAD_BYTES = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  have_data,
    input  byte_t head,
    output logic  take,
    output logic  sink_vld,
    output byte_t sink_byte,
    input  logic [$clog2(LOAD_BYTES)-1:0] rd_addr,
    output byte_t rd_data
);
    localparam int AW = $clog2(LOAD_BYTES);
    localparam logic [AW-1:0] LAST = AW'(LOAD_BYTES - 1);

    typedef struct packed {
        logic [LOAD_BYTES-1:0][7:0] store;
        logic [AW-1:0]              wa;
        logic                       gap;
        logic                       vld;
        logic [7:0]                 last;
    } sink_st_t;

    sink_st_t st_d, st_q;

    assign take      = have_data && !st_q.gap;
    assign sink_vld  = st_q.vld;
    assign sink_byte = st_q.last;
    assign rd_data   = st_q.store[rd_addr];

    always_comb begin
        st_d     = st_q;
        st_d.gap = take;
        st_d.vld = take;
        if (take) begin
            st_d.last          = head;
            st_d.store[st_q.wa] = head;
            st_d.wa = (st_q.wa == LAST) ? '0 : st_q.wa + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    sink_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sink_vld |=> !sink_vld);

endmodule

// File: rtl/cfgp_readback.sv
module cfgp_readback
    import cfgp_pkg::*;
#(
    parameter int LOAD_BYTES = 12
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs,
    input  logic  rd_act,
    input  byte_t rd_data,
    output logic [$clog2(LOAD_BYTES)-1:0] rd_addr,
    output byte_t dout,
    output logic  dout_en
);
    localparam int AW = $clog2(LOAD_BYTES);
    localparam logic [AW-1:0] LAST = AW'(LOAD_BYTES - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
    } rb_st_t;

    rb_st_t st_d, st_q;

    assign rd_addr = st_q.addr;
    assign dout_en = rd_act;
    assign dout    = rd_act ? bitrev8(rd_data) : '0;

    always_comb begin
        st_d = st_q;
        if (!cs) begin
            st_d.addr = '0;
        end else if (rd_act) begin
            st_d.addr = (st_q.addr == LAST) ? '0 : st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    addr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> (rd_addr == '0));

endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
    import cfgp_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int LOAD_BYTES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       cs,
    input  logic       wr,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_en,
    output logic       busy,
    output logic       done,
    output logic       sink_vld,
    output logic [7:0] sink_byte
);
    localparam int CW = $clog2(LOAD_BYTES + 1);
    localparam int AW = $clog2(LOAD_BYTES);
    localparam logic [CW-1:0] LASTC = CW'(LOAD_BYTES - 1);

    typedef struct packed {
        logic [CW-1:0] acc;
        logic          done;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          mode_ok, push, rd_act, full, empty, take;
    byte_t         head, rd_data;
    logic [AW-1:0] rd_addr;

    assign mode_ok = (mode_sel == MODE_PARALLEL);
    assign push    = mode_ok && cs && wr && !st_q.done && !full;
    assign rd_act  = mode_ok && cs && !wr && st_q.done;
    assign busy    = full;
    assign done    = st_q.done;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.acc = st_q.acc + 1'b1;
            if (st_q.acc == LASTC) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cfgp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (bitrev8(din)),
        .pop   (take),
        .rdata (head),
        .full  (full),
        .empty (empty)
    );

    cfgp_sink #(.LOAD_BYTES(LOAD_BYTES)) u_sink (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_data (!empty),
        .head      (head),
        .take      (take),
        .sink_vld  (sink_vld),
        .sink_byte (sink_byte),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    cfgp_readback #(.LOAD_BYTES(LOAD_BYTES)) u_rb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .rd_act  (rd_act),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .dout    (dout),
        .dout_en (dout_en)
    );

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R7
    read_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> done);

    // R6
    no_push_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(st_q.acc));

endmodule

// File: tb/sim_cfg_byte_port.sv
module sim_cfg_byte_port;
    localparam int LOADN = 12;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] mode_sel = 3'b000;
    logic       cs = 0, wr = 0;
    logic [7:0] din = 0;
    logic [7:0] dout, sink_byte;
    logic       dout_en, busy, done, sink_vld;

    int errors = 0, checks = 0;
    logic [7:0] exp_b [0:31];
    int exp_n = 0, sink_idx = 0, stalls = 0;
    logic prev_vld = 0;
    logic finished = 0;

    always #10 clk = ~clk;

    cfg_byte_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs(cs), .wr(wr),
        .din(din), .dout(dout), .dout_en(dout_en), .busy(busy),
        .done(done), .sink_vld(sink_vld), .sink_byte(sink_byte)
    );

    function automatic logic [7:0] rev(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[7-i] = b[i];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // sink monitor: R4 order and spacing, R5 reversal
    always @(negedge clk) begin
        if (rst_n && sink_vld) begin
            chk("R4 sink spacing", {31'd0, prev_vld}, 32'd0);
            if (sink_idx >= exp_n) chk("R4 unexpected sink byte", sink_idx, exp_n);
            else chk("R5 sink byte reversed", sink_byte, rev(exp_b[sink_idx]));
            sink_idx++;
        end
        prev_vld = sink_vld;
    end

    task automatic t_reset();
        rst_n = 0; cs = 0; wr = 0; mode_sel = 3'b110;
        repeat (3) @(negedge clk);
        chk("R10 busy in reset", busy, 0);
        chk("R10 done in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 busy after reset", busy, 0);
        chk("R10 dout_en after reset", dout_en, 0);
        chk("R10 sink_vld after reset", sink_vld, 0);
    endtask

    // raw writes every cycle, no busy wait
    task automatic blast(input int n, input logic [2:0] m, input logic c, input logic w);
        mode_sel = m; cs = c; wr = w;
        for (int i = 0; i < n; i++) begin
            din = 8'hA0 + 8'(i);
            @(negedge clk);
        end
        cs = 0; wr = 0; mode_sel = 3'b110;
    endtask

    task automatic t_wrong_mode();
        blast(8, 3'b011, 1, 1);
        chk("R1 busy stays low under other mode", busy, 0);
        blast(8, 3'b100, 1, 1);
        chk("R1 busy stays low under mode 100", busy, 0);
        repeat (4) @(negedge clk);
        chk("R1 no sink output", sink_idx, 0);
    endtask

    task automatic t_strobes();
        blast(8, 3'b110, 0, 1);
        chk("R2 no accept without cs", busy, 0);
        mode_sel = 3'b110; cs = 1; wr = 0;
        #1;
        chk("R7 no readback before done", dout_en, 0);
        chk("R7 dout zero before done", dout, 0);
        @(negedge clk);
        blast(8, 3'b110, 1, 0);
        chk("R2 no accept with wr low", busy, 0);
        repeat (3) @(negedge clk);
        chk("R2 sink untouched", sink_idx, 0);
    endtask

    task automatic send(input logic [7:0] b);
        din = b; cs = 1; wr = 1; mode_sel = 3'b110;
        while (busy) begin
            stalls++;
            @(negedge clk);
        end
        exp_b[exp_n] = b; exp_n++;
        @(negedge clk);
    endtask

    task automatic t_burst();
        int rose_at = -1;
        for (int i = 0; i < LOADN; i++) begin
            chk("R6 done low before last byte", done, 0);
            if (busy && rose_at < 0) rose_at = i;
            send(8'h01 + 8'(i * 37));
        end
        cs = 0; wr = 0;
        chk("R6 done after last byte", done, 1);
        checks++;
        if (stalls == 0) begin
            errors++;
            $display("FAIL R3 no stall in burst actual=0 expected>0");
        end
        checks++;
        if (rose_at < 0 || rose_at > 8) begin
            errors++;
            $display("FAIL R3 busy rise index actual=%0d expected<=8", rose_at);
        end
        repeat (20) @(negedge clk);
        chk("R3 busy low after drain", busy, 0);
        chk("R4 all bytes reached sink", sink_idx, LOADN);
    endtask

    task automatic t_after_done();
        blast(8, 3'b110, 1, 1);
        chk("R6 writes ignored after done busy", busy, 0);
        repeat (4) @(negedge clk);
        chk("R6 no sink after done", sink_idx, LOADN);
        chk("R6 done sticky", done, 1);
    endtask

    task automatic readn(input int n, input int start);
        mode_sel = 3'b110; cs = 1; wr = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            chk("R7 dout_en during read", dout_en, 1);
            chk("R7 readback byte", dout, exp_b[(start + i) % LOADN]);
            @(negedge clk);
        end
    endtask

    task automatic t_readback();
        readn(3, 0);
        wr = 1;
        #1;
        chk("R7 no drive with wr high", dout_en, 0);
        @(negedge clk);
        readn(2, 3);
        cs = 0;
        @(negedge clk);
        readn(LOADN + 2, 0);
        cs = 0;
        @(negedge clk);
    endtask

    task automatic t_restart();
        readn(5, 0);
        cs = 0;
        #1;
        chk("R7 no drive with cs low", dout_en, 0);
        @(negedge clk);
        readn(1, 0);
        cs = 0;
        @(negedge clk);
    endtask

    task automatic t_wrap();
        readn(LOADN, 0);
        readn(1, 0);   // R9 wraps to first byte
        cs = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_wrong_mode();
        t_strobes();
        t_burst();
        t_after_done();
        t_readback();
        t_restart();
        t_wrap();
        finished = 1;
        finish_run();
    end

endmodule